// File: doc/BRIEF.md
# Debug Access Lockout Gate

This block sits between an external serial debug port and the on-chip memory spaces. It decides whether each debug request may reach its target. Firmware arms or disarms the gate by writing code bytes to an 8-bit processor port. The block snoops those writes and keeps a single lock flag. Each debug request is classified by address into one of several target spaces: data RAM, program OTP, EEPROM, the controller/interface control test register, general test registers, or unmapped.

While the gate is locked, only the general test registers can be reached from the debug side. Denied reads return zero, denied writes never reach the memory side, and a deny strobe marks every refused request. Processor accesses are never blocked. The lock flag is cleared only by power-on reset and survives a watchdog-initiated processor reset.

The decision is purely combinational from the lock flag and the decoded address. A memory wrapper can therefore use `mem_req`, `mem_we` and `mem_space` in the same cycle as the debug strobe.

Top module: `dbg_lock_gate`

## Requirements
- R1: After power-on reset (`rst_n` low, then released) the gate is unlocked. With no request active, `dbg_gnt`, `dbg_deny`, `mem_req`, `mem_we` and `dbg_rdata` are all zero.
- R2: A port write (`cpu_port_we` high with `wdt_rst_n` high) of 0xAA sets the lock on the next rising clock edge.
- R3: A port write of 0x00 while locked clears the lock on the next rising clock edge.
- R4: A port write of any value other than 0xAA and 0x00 leaves the lock state unchanged, from either state. Writing 0x00 while unlocked leaves the gate unlocked.
- R5: A debug request in the same cycle as a lock-changing port write is judged against the lock state held before that write.
- R6: While locked, requests to RAM, OTP, EEPROM and the control test register are denied, and requests to general test registers are granted.
- R7: While unlocked, requests to every mapped space are granted. Requests to unmapped pages are denied in both states.
- R8: A denied request raises `dbg_deny` in the same cycle as `dbg_req` and drives `dbg_rdata` to 0x00. A granted read returns `mem_rdata` on `dbg_rdata` in that cycle.
- R9: A denied request never reaches the memory side (`mem_req` and `mem_we` stay low). A granted write raises both `mem_req` and `mem_we`.
- R10: `cpu_gnt` follows `cpu_req` in every lock state.
- R11: While `wdt_rst_n` is low, port writes are ignored and the lock flag holds its value. A watchdog reset therefore never clears the lock.
- R12: The address map uses the page number `dbg_addr[15:12]` and the offset `dbg_addr[11:0]`. Page 0 is RAM (code 1), pages 3 and 4 are OTP (code 2), page 5 is EEPROM (code 3), and page 7 is the test page. On the test page, offset 0 is the control test register (code 4) and any other offset is a general test register (code 5). `mem_space` carries the code of a granted request and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| wdt_rst_n | input | 1 | Watchdog processor reset, active low, sampled synchronously |
| cpu_port_we | input | 1 | Processor write strobe to the lock port |
| cpu_port_wdata | input | 8 | Byte written to the lock port |
| cpu_req | input | 1 | Processor memory request |
| cpu_gnt | output | 1 | Processor grant |
| dbg_req | input | 1 | Debug request strobe |
| dbg_we | input | 1 | Debug request is a write |
| dbg_addr | input | 16 | Debug address |
| dbg_wdata | input | 8 | Debug write data |
| dbg_rdata | output | 8 | Debug read data (0x00 when refused) |
| dbg_gnt | output | 1 | Debug request granted |
| dbg_deny | output | 1 | Debug request refused |
| mem_req | output | 1 | Request forwarded to memory side |
| mem_we | output | 1 | Forwarded write enable |
| mem_addr | output | 16 | Forwarded address |
| mem_wdata | output | 8 | Forwarded write data |
| mem_space | output | 3 | Target space code of a granted request |
| mem_rdata | input | 8 | Read data from memory side |

## Verification
The bench builds the gate with its defaults: a 16-bit address, 4-bit pages and an 8-bit port. At that size every page can be swept in both lock states with both access directions, and at the first, second and last offset. Every one of the 256 port byte values is also written from each lock state. This reaches every space code, every lock transition and every ignored value. Directed sequences add the same-cycle write-and-request case, port writes during a watchdog reset, and a final power-on reset out of the locked state.

// File: rtl/dbg_lock_pkg.sv
package dbg_lock_pkg;
  typedef enum logic [2:0] {
    SP_NONE  = 3'd0,
    SP_RAM   = 3'd1,
    SP_OTP   = 3'd2,
    SP_EE    = 3'd3,
    SP_CTRL  = 3'd4,
    SP_GTEST = 3'd5
  } space_e;
endpackage

// File: rtl/dbg_lock_rst_sync.sv
module dbg_lock_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/dbg_lock_flag.sv
module dbg_lock_flag #(
  parameter int          PORT_W      = 8,
  parameter logic [7:0]  LOCK_CODE   = 8'hAA,
  parameter logic [7:0]  UNLOCK_CODE = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wdt_rst_n,
  input  logic              port_we,
  input  logic [PORT_W-1:0] port_wdata,
  output logic              locked
);
  localparam logic [PORT_W-1:0] LOCK_V   = PORT_W'(LOCK_CODE);
  localparam logic [PORT_W-1:0] UNLOCK_V = PORT_W'(UNLOCK_CODE);

  logic wr_ok;
  logic hit_lock;
  logic hit_unlock;
  logic lock_en;
  logic lock_d;
  logic lock_q;

  always_comb begin
    wr_ok      = port_we && wdt_rst_n;
    hit_lock   = wr_ok && (port_wdata == LOCK_V);
    hit_unlock = wr_ok && (port_wdata == UNLOCK_V);
    lock_en    = hit_lock || hit_unlock;
    lock_d     = hit_lock;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lock_q <= 1'b0;
    else if (lock_en) lock_q <= lock_d;
  end

  assign locked = lock_q;

  a_r2_lock_set: assert property (@(posedge clk) disable iff (!rst_n)
    (port_we && wdt_rst_n && port_wdata == LOCK_V) |=> locked);

  a_r3_lock_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (port_we && wdt_rst_n && port_wdata == UNLOCK_V) |=> !locked);

  a_r4_other_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (port_we && port_wdata != LOCK_V && port_wdata != UNLOCK_V) |=> $stable(locked));

  a_r11_wdt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wdt_rst_n) |=> $stable(locked));
endmodule

// File: rtl/dbg_lock_decode.sv
module dbg_lock_decode
  import dbg_lock_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int PAGE_W    = 4,
  parameter int PG_RAM    = 0,
  parameter int PG_OTP_LO = 3,
  parameter int PG_OTP_HI = 4,
  parameter int PG_EE     = 5,
  parameter int PG_TEST   = 7,
  parameter int CTRL_OFS  = 0
) (
  input  logic [ADDR_W-1:0] addr,
  output space_e            space
);
  localparam int OFS_W = ADDR_W - PAGE_W;

  logic [PAGE_W-1:0] page;
  logic [OFS_W-1:0]  ofs;

  always_comb begin
    page  = addr[ADDR_W-1 -: PAGE_W];
    ofs   = addr[OFS_W-1:0];
    space = SP_NONE;
    if (page == PAGE_W'(PG_RAM))
      space = SP_RAM;
    else if (page >= PAGE_W'(PG_OTP_LO) && page <= PAGE_W'(PG_OTP_HI))
      space = SP_OTP;
    else if (page == PAGE_W'(PG_EE))
      space = SP_EE;
    else if (page == PAGE_W'(PG_TEST))
      space = (ofs == OFS_W'(CTRL_OFS)) ? SP_CTRL : SP_GTEST;
  end
endmodule

// File: rtl/dbg_lock_gate.sv
module dbg_lock_gate
  import dbg_lock_pkg::*;
#(
  parameter int         ADDR_W      = 16,
  parameter int         DATA_W      = 8,
  parameter int         PORT_W      = 8,
  parameter int         PAGE_W      = 4,
  parameter logic [7:0] LOCK_CODE   = 8'hAA,
  parameter logic [7:0] UNLOCK_CODE = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wdt_rst_n,
  input  logic              cpu_port_we,
  input  logic [PORT_W-1:0] cpu_port_wdata,
  input  logic              cpu_req,
  output logic              cpu_gnt,
  input  logic              dbg_req,
  input  logic              dbg_we,
  input  logic [ADDR_W-1:0] dbg_addr,
  input  logic [DATA_W-1:0] dbg_wdata,
  output logic [DATA_W-1:0] dbg_rdata,
  output logic              dbg_gnt,
  output logic              dbg_deny,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [2:0]        mem_space,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic   rst_sync_n;
  logic   locked;
  space_e space;
  logic   allowed;

  dbg_lock_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dbg_lock_flag #(
    .PORT_W      (PORT_W),
    .LOCK_CODE   (LOCK_CODE),
    .UNLOCK_CODE (UNLOCK_CODE)
  ) u_flag (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wdt_rst_n  (wdt_rst_n),
    .port_we    (cpu_port_we),
    .port_wdata (cpu_port_wdata),
    .locked     (locked)
  );

  dbg_lock_decode #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W)
  ) u_dec (
    .addr  (dbg_addr),
    .space (space)
  );

  always_comb begin
    if (locked) allowed = (space == SP_GTEST);
    else        allowed = (space != SP_NONE);
    dbg_gnt   = dbg_req && allowed;
    dbg_deny  = dbg_req && !allowed;
    mem_req   = dbg_gnt;
    mem_we    = dbg_gnt && dbg_we;
    mem_addr  = dbg_addr;
    mem_wdata = dbg_wdata;
    mem_space = dbg_gnt ? 3'(space) : 3'(SP_NONE);
    dbg_rdata = (dbg_gnt && !dbg_we) ? mem_rdata : '0;
    cpu_gnt   = cpu_req;
  end

  a_r6_locked_gtest_only: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (locked && mem_req) |-> (mem_space == 3'(SP_GTEST)));

  a_r8_deny_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dbg_deny |-> (dbg_rdata == '0));

  a_r9_deny_blocks_mem: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dbg_deny |-> (!mem_req && !mem_we));

  a_r8_one_outcome: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({dbg_gnt, dbg_deny}) && (dbg_req == (dbg_gnt || dbg_deny)));

  a_r7_unmapped_deny: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dbg_req && space == SP_NONE) |-> dbg_deny);
endmodule

// File: tb/dbg_lock_gate_bench.sv
module dbg_lock_gate_bench;
  logic        clk = 1'b0;
  logic        rst_n, wdt_rst_n, cpu_port_we, cpu_req, dbg_req, dbg_we;
  logic [7:0]  cpu_port_wdata, dbg_wdata, dbg_rdata, mem_wdata, mem_rdata;
  logic [15:0] dbg_addr, mem_addr;
  logic        cpu_gnt, dbg_gnt, dbg_deny, mem_req, mem_we;
  logic [2:0]  mem_space;

  int checks = 0;
  int errors = 0;
  bit exp_lk = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign mem_rdata = {mem_addr[3:0], 4'hC};

  dbg_lock_gate u_dbg_lock_gate (
    .clk(clk), .rst_n(rst_n), .wdt_rst_n(wdt_rst_n),
    .cpu_port_we(cpu_port_we), .cpu_port_wdata(cpu_port_wdata),
    .cpu_req(cpu_req), .cpu_gnt(cpu_gnt),
    .dbg_req(dbg_req), .dbg_we(dbg_we), .dbg_addr(dbg_addr),
    .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata), .dbg_gnt(dbg_gnt),
    .dbg_deny(dbg_deny), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_space(mem_space),
    .mem_rdata(mem_rdata)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int space_of(input logic [15:0] a);
    int p = int'(a[15:12]);
    if (p == 0) return 1;
    if (p == 3 || p == 4) return 2;
    if (p == 5) return 3;
    if (p == 7) return (a[11:0] == 12'h000) ? 4 : 5;
    return 0;
  endfunction

  function automatic bit allowed_of(input logic [15:0] a, input bit lk);
    int s = space_of(a);
    return lk ? (s == 5) : (s != 0);
  endfunction

  task automatic port_write(input logic [7:0] v);
    @(negedge clk);
    dbg_req = 1'b0;
    cpu_port_we = 1'b1;
    cpu_port_wdata = v;
    if (wdt_rst_n) begin
      if (v == 8'hAA) exp_lk = 1'b1;
      else if (v == 8'h00) exp_lk = 1'b0;
    end
    @(negedge clk);
    cpu_port_we = 1'b0;
  endtask

  // full comparison of one debug access against the model
  task automatic access(input logic [15:0] a, input bit we, input string req);
    bit al;
    logic [7:0] er;
    @(negedge clk);
    dbg_req = 1'b1; dbg_we = we; dbg_addr = a; dbg_wdata = 8'h3C;
    #2;
    al = allowed_of(a, exp_lk);
    er = (al && !we) ? {a[3:0], 4'hC} : 8'h00;
    check(dbg_gnt == al && dbg_deny == !al && mem_req == al &&
          mem_we == (al && we) && dbg_rdata == er &&
          mem_space == (al ? 3'(space_of(a)) : 3'd0), req,
          {dbg_gnt, dbg_deny, mem_req, mem_we, mem_space, dbg_rdata},
          {al, !al, al, al && we, al ? 3'(space_of(a)) : 3'd0, er});
    @(negedge clk);
    dbg_req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wdt_rst_n = 1'b1; cpu_port_we = 1'b0; cpu_port_wdata = 8'h00;
    cpu_req = 1'b0; dbg_req = 1'b0; dbg_we = 1'b0; dbg_addr = '0; dbg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    // R1: idle outputs after reset
    check(!dbg_gnt && !dbg_deny && !mem_req && !mem_we && dbg_rdata == 8'h00,
          "R1 idle", {dbg_gnt, dbg_deny, mem_req, mem_we, dbg_rdata}, 0);
    access(16'h3000, 1'b0, "R1 unlocked after reset");

    // R6 R7 R8 R9 R12: sweep every page, both lock states, both directions
    for (int lk = 0; lk < 2; lk++) begin
      port_write(lk ? 8'hAA : 8'h00);
      for (int p = 0; p < 16; p++)
        for (int o = 0; o < 3; o++)
          for (int w = 0; w < 2; w++)
            access({4'(p), (o == 0) ? 12'h000 : (o == 1) ? 12'h001 : 12'hFFF},
                   w[0], lk ? "R6 R8 R9 R12 locked sweep" : "R7 R8 R9 R12 unlocked sweep");
    end

    // R2 R4: every byte value from unlocked
    for (int v = 0; v < 256; v++) begin
      port_write(8'h00);
      port_write(8'(v));
      access(16'h4010, 1'b0, (v == 8'hAA) ? "R2 lock code" : "R4 from unlocked");
    end
    // R3 R4: every byte value from locked
    for (int v = 0; v < 256; v++) begin
      port_write(8'hAA);
      port_write(8'(v));
      access(16'h5020, 1'b0, (v == 0) ? "R3 unlock code" : "R4 from locked");
    end

    // R5: same-cycle write and request judged on old state
    port_write(8'h00);
    @(negedge clk);
    cpu_port_we = 1'b1; cpu_port_wdata = 8'hAA;
    dbg_req = 1'b1; dbg_we = 1'b0; dbg_addr = 16'h3004;
    #2;
    check(dbg_gnt && !dbg_deny, "R5 old unlocked state", {dbg_gnt, dbg_deny}, 2'b10);
    @(negedge clk);
    cpu_port_we = 1'b0; exp_lk = 1'b1;
    #2;
    check(!dbg_gnt && dbg_deny, "R5 lock after edge", {dbg_gnt, dbg_deny}, 2'b01);
    cpu_port_we = 1'b1; cpu_port_wdata = 8'h00;
    #2;
    check(!dbg_gnt && dbg_deny, "R5 old locked state", {dbg_gnt, dbg_deny}, 2'b01);
    @(negedge clk);
    cpu_port_we = 1'b0; exp_lk = 1'b0;
    #2;
    check(dbg_gnt && !dbg_deny, "R5 unlock after edge", {dbg_gnt, dbg_deny}, 2'b10);
    dbg_req = 1'b0;

    // R10: processor grant in both states
    for (int lk = 0; lk < 2; lk++) begin
      port_write(lk ? 8'hAA : 8'h00);
      @(negedge clk); cpu_req = 1'b1; #2;
      check(cpu_gnt == 1'b1, "R10 cpu grant", cpu_gnt, 1);
      cpu_req = 1'b0; #2;
      check(cpu_gnt == 1'b0, "R10 cpu idle", cpu_gnt, 0);
    end

    // R11: watchdog reset keeps lock and masks port writes
    port_write(8'hAA);
    @(negedge clk); wdt_rst_n = 1'b0;
    port_write(8'h00);
    access(16'h0100, 1'b0, "R11 locked during watchdog");
    @(negedge clk); wdt_rst_n = 1'b1;
    access(16'h3100, 1'b0, "R11 locked after watchdog");
    access(16'h7001, 1'b1, "R11 general test open after watchdog");
    port_write(8'h00);
    @(negedge clk); wdt_rst_n = 1'b0;
    port_write(8'hAA);
    @(negedge clk); wdt_rst_n = 1'b1;
    access(16'h3100, 1'b0, "R11 unlocked kept through watchdog");

    // R1: power-on reset from locked
    port_write(8'hAA);
    access(16'h0000, 1'b0, "R1 locked before power-on reset");
    @(negedge clk); rst_n = 1'b0; exp_lk = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    access(16'h0000, 1'b0, "R1 unlocked after power-on reset");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule